// File: doc/BRIEF.md
# Predecrement Block-Store Sequencer

This block sequences a multi-register store in predecrement address mode. A single command carries a 16-bit register-select mask, the number of the address register that serves as the base, a size select (word or long) and a flat copy of all sixteen registers. The block then issues one memory write for each selected register, from the highest-numbered register down to the lowest. The address of each write is one transfer size below the address of the write before it. When the last write has been acknowledged, the block reports the new value of the base register so that the register file can take it.

Mask and register numbering: bit i of the mask and slice i of the register bus (bits 32*i+31 down to 32*i) both belong to register i. Registers 0 to 7 are data registers D0 to D7, and registers 8 to 15 are address registers A0 to A7. The base register number b therefore selects register 8+b. The command port and the write port both use valid/ready. A command is taken in the cycle in which `cmd_valid` and `cmd_ready` are both high. A write completes in the cycle in which `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, the write that is on offer stays on offer without change, so the memory side can stall each write for as long as it needs.

Top module: `predec_store_seq`

## Requirements
- R1: Selected registers are written in strictly descending register number: A7 down to A0, then D7 down to D0. Bit i of `cmd_mask` selects register i, where 0-7 are D0-D7 and 8-15 are A0-A7.
- R2: The first write goes to the base register's value at command acceptance minus the transfer size: 4 when `cmd_long`=1, 2 when `cmd_long`=0.
- R3: Each later write of the same command goes to the previous write address minus the transfer size.
- R4: When the base register (index 8+`cmd_base`) is selected, the data written for it is its value at acceptance minus one transfer size, not its original value.
- R5: For long size, `wr_data` is the full 32-bit register and `wr_long`=1. For word size, `wr_data` is the register's low 16 bits zero-extended and `wr_long`=0.
- R6: In the cycle after the last write is acknowledged, `wb_valid` is high for exactly one cycle, with `wb_reg`=`cmd_base` and `wb_data` equal to the last write address. `cmd_ready` is high in the following cycle.
- R7: A command with an all-zero mask causes no write and no writeback, and `cmd_ready` is high again in the next cycle.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold steady. A new write is offered only after the current one is acknowledged.
- R9: `cmd_ready` is high only when no command is in progress. Register values are captured at acceptance, and later changes on `cmd_regs` do not affect that command.
- R10: After reset `cmd_ready`=1, `wr_valid`=0 and `wb_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_mask | input | 16 | Register select mask |
| cmd_base | input | 3 | Base address register number |
| cmd_long | input | 1 | 1 = long transfers, 0 = word transfers |
| cmd_regs | input | 512 | All sixteen register values, register i in slice i |
| wr_valid | output | 1 | Write offered |
| wr_ready | input | 1 | Write acknowledge |
| wr_addr | output | 32 | Write address |
| wr_data | output | 32 | Write data |
| wr_long | output | 1 | Write size, 1 = long |
| wb_valid | output | 1 | One-cycle base register update |
| wb_reg | output | 3 | Base register number to update |
| wb_data | output | 32 | New base register value |

## Verification
The decrement of the running address and the store of the base register's own value meet in the same write beat whenever the base register is in the mask. Both values are derived from the same starting value, and a mistake in either shows up at the same time. The bench sweeps every base register number against every single-bit mask, a full mask, an empty mask and a series of pseudo-random masks, in both sizes. This places the base register at every position of the walk, including first, last and alone. For each beat the bench computes the expected address, and the expected data (with the decremented base value), by arithmetic from the captured register values, and compares them with what the block offers. The acknowledge of the final write and the writeback that follows it are checked cycle by cycle, with stalls of varying length inserted before each acknowledge.

// File: rtl/pse_pkg.sv
package pse_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WB   = 2'd2
  } pse_state_e;
endpackage

// File: rtl/pse_pick_high.sv
// Selects the highest set bit of a request vector.
module pse_pick_high #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/pse_addr_step.sv
// One predecrement step: long moves by 4, word by 2.
module pse_addr_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur,
  input  logic          lng,
  output logic [AW-1:0] nxt
);
  localparam logic [AW-1:0] STEP_L = AW'(4);
  localparam logic [AW-1:0] STEP_W = AW'(2);
  assign nxt = cur - (lng ? STEP_L : STEP_W);
endmodule

// File: rtl/predec_store_seq.sv
module predec_store_seq #(
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG),
  localparam int BW  = $clog2(NREG / 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [NREG-1:0]    cmd_mask,
  input  logic [BW-1:0]      cmd_base,
  input  logic               cmd_long,
  input  logic [NREG*DW-1:0] cmd_regs,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [DW-1:0]      wr_addr,
  output logic [DW-1:0]      wr_data,
  output logic               wr_long,
  output logic               wb_valid,
  output logic [BW-1:0]      wb_reg,
  output logic [DW-1:0]      wb_data
);
  import pse_pkg::*;

  localparam int HW = DW / 2;
  localparam logic [DW-1:0] STEP_L = DW'(4);
  localparam logic [DW-1:0] STEP_W = DW'(2);

  pse_state_e           state_q;
  logic [NREG-1:0]      mask_q;
  logic [BW-1:0]        base_q;
  logic                 long_q;
  logic [DW-1:0]        cur_q;
  logic [DW-1:0]        snap_q [NREG];

  logic [IW-1:0]        pick_idx;
  logic                 pick_any;
  logic [DW-1:0]        base_dec;
  logic [DW-1:0]        pick_val;
  logic [NREG-1:0]      mask_left;
  logic                 accept;
  logic                 beat;
  logic [IW-1:0]        base_idx;

  assign base_idx = {1'b1, base_q};

  pse_pick_high #(.N(NREG)) u_pick (
    .req (mask_q),
    .idx (pick_idx),
    .any (pick_any)
  );

  // Running address step
  pse_addr_step #(.AW(DW)) u_step_run (
    .cur (cur_q),
    .lng (long_q),
    .nxt (wr_addr)
  );

  // Value stored for the base register itself
  pse_addr_step #(.AW(DW)) u_step_base (
    .cur (snap_q[base_idx]),
    .lng (long_q),
    .nxt (base_dec)
  );

  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign wr_valid  = (state_q == ST_RUN) && pick_any;
  assign beat      = wr_valid && wr_ready;
  assign wr_long   = long_q;

  always_comb begin
    pick_val = (pick_idx == base_idx) ? base_dec : snap_q[pick_idx];
    wr_data  = long_q ? pick_val : {{(DW - HW){1'b0}}, pick_val[HW-1:0]};
    mask_left = mask_q;
    mask_left[pick_idx] = 1'b0;
  end

  assign wb_valid = (state_q == ST_WB);
  assign wb_reg   = base_q;
  assign wb_data  = cur_q;

  // Register snapshot, data path only
  always_ff @(posedge clk) begin
    if (accept) begin
      for (int i = 0; i < NREG; i++) snap_q[i] <= cmd_regs[i*DW +: DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      base_q  <= '0;
      long_q  <= 1'b0;
      cur_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            mask_q  <= cmd_mask;
            base_q  <= cmd_base;
            long_q  <= cmd_long;
            cur_q   <= cmd_regs[(NREG/2 + int'(cmd_base))*DW +: DW];
            state_q <= (|cmd_mask) ? ST_RUN : ST_IDLE;
          end
        end
        ST_RUN: begin
          if (beat) begin
            mask_q <= mask_left;
            cur_q  <= wr_addr;
            if (mask_left == '0) state_q <= ST_WB;
          end
        end
        ST_WB:   state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_ORDER_DESC: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> (!wr_valid || pick_idx < $past(pick_idx))); // R1

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> (!wr_valid || wr_addr == $past(wr_addr) - (wr_long ? STEP_L : STEP_W))); // R3

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R8

  AST_WB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> (!wb_valid && cmd_ready)); // R6

  AST_WB_LAST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_data == $past(wr_addr) && !wr_valid)); // R6

  AST_BUSY_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid || wb_valid) |-> !cmd_ready); // R9
endmodule

// File: tb/predec_store_seq_test.sv
module predec_store_seq_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [15:0]  cmd_mask = '0;
  logic [2:0]   cmd_base = '0;
  logic         cmd_long = 1'b0;
  logic [511:0] cmd_regs;
  logic         wr_valid;
  logic         wr_ready = 1'b0;
  logic [31:0]  wr_addr, wr_data;
  logic         wr_long;
  logic         wb_valid;
  logic [2:0]   wb_reg;
  logic [31:0]  wb_data;

  logic [31:0]  rv [16];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 16; i++) cmd_regs[i*32 +: 32] = rv[i];
  end

  predec_store_seq uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_mask(cmd_mask), .cmd_base(cmd_base), .cmd_long(cmd_long), .cmd_regs(cmd_regs),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_long(wr_long), .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [15:0] mask, input int base, input bit lng,
                         input logic [31:0] bval, input int seed);
    logic [31:0] snap [16];
    logic [31:0] step, addr, d;
    logic [63:0] hold;
    step = lng ? 32'd4 : 32'd2;
    for (int i = 0; i < 16; i++)
      rv[i] = 32'hA500_0000 ^ (32'(i) << 20) ^ (32'(seed) * 32'h0001_9E37) ^ 32'(i);
    rv[8 + base] = bval;
    for (int i = 0; i < 16; i++) snap[i] = rv[i];
    @(negedge clk);
    chk(cmd_ready === 1'b1, "R9 idle ready", {63'd0, cmd_ready}, 64'd1);
    cmd_valid = 1'b1; cmd_mask = mask; cmd_base = 3'(base); cmd_long = lng;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 16; i++) rv[i] = ~rv[i];   // R9: later changes must not matter
    if (mask == 16'h0000) begin
      chk(wr_valid === 1'b0 && wb_valid === 1'b0, "R7 empty mask no write/wb",
          {62'd0, wr_valid, wb_valid}, 64'd0);
      chk(cmd_ready === 1'b1, "R7 ready after empty", {63'd0, cmd_ready}, 64'd1);
      return;
    end
    chk(cmd_ready === 1'b0, "R9 busy not ready", {63'd0, cmd_ready}, 64'd0);
    addr = bval;
    for (int i = 15; i >= 0; i--) begin
      if (mask[i]) begin
        addr = addr - step;   // R2 first, R3 later
        d = (i == 8 + base) ? bval - step : snap[i];   // R4
        if (!lng) d = {16'h0000, d[15:0]};   // R5
        hold = {wr_addr, wr_data};
        for (int s = 0; s < (i + seed) % 3; s++) begin
          @(negedge clk);
          chk(wr_valid === 1'b1 && {wr_addr, wr_data} === hold, "R8 hold under stall",
              {wr_addr, wr_data}, hold);
        end
        chk(wr_valid === 1'b1, "R8 write offered", {63'd0, wr_valid}, 64'd1);
        chk(wr_addr === addr, "R1/R2/R3 address", {32'd0, wr_addr}, {32'd0, addr});
        chk(wr_data === d, (i == 8 + base) ? "R4 base data" : "R1/R5 data",
            {32'd0, wr_data}, {32'd0, d});
        chk(wr_long === lng, "R5 size flag", {63'd0, wr_long}, {63'd0, lng});
        wr_ready = 1'b1;
        @(negedge clk);
        wr_ready = 1'b0;
      end
    end
    chk(wr_valid === 1'b0 && wb_valid === 1'b1, "R6 writeback pulse",
        {62'd0, wr_valid, wb_valid}, 64'd1);
    chk(wb_reg === 3'(base) && wb_data === addr, "R6 writeback value",
        {29'd0, wb_reg, wb_data}, {29'd0, 3'(base), addr});
    @(negedge clk);
    chk(wb_valid === 1'b0 && cmd_ready === 1'b1, "R6 pulse ends, ready",
        {62'd0, wb_valid, cmd_ready}, 64'd1);
  endtask

  initial begin
    logic [15:0] lfsr;
    int seed;
    for (int i = 0; i < 16; i++) rv[i] = '0;
    #1;
    chk(cmd_ready === 1'b1 && wr_valid === 1'b0 && wb_valid === 1'b0, "R10 reset state",
        {61'd0, cmd_ready, wr_valid, wb_valid}, 64'd4);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(cmd_ready === 1'b1 && wr_valid === 1'b0 && wb_valid === 1'b0, "R10 after reset",
        {61'd0, cmd_ready, wr_valid, wb_valid}, 64'd4);
    // D2/D7/A0/A1/A3/A6, base A1 = 0x80, long
    run_cmd(16'h4B84, 1, 1'b1, 32'h0000_0080, 0);
    seed = 1;
    lfsr = 16'hACE1;
    for (int b = 0; b < 8; b++) begin
      for (int l = 0; l < 2; l++) begin
        for (int k = 0; k < 16; k++) begin
          run_cmd(16'(1 << k), b, l[0], 32'h0000_8000 + 32'(seed << 4), seed);
          seed++;
        end
        run_cmd(16'hFFFF, b, l[0], 32'h0000_0040, seed); seed++;
        run_cmd(16'h0000, b, l[0], 32'h0000_1000, seed); seed++;
        for (int k = 0; k < 12; k++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          run_cmd(lfsr, b, l[0], 32'h0001_0000 + 32'(seed << 3), seed);
          seed++;
        end
      end
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule